// File: doc/BRIEF.md
# Line Sensor Section Sequencer

This block is the digital sequencing logic of one section of a linear image sensor. A single serial-input pulse, captured on a rising clock edge, starts a readout. The pulse then moves through a shift register one stage per clock. Each stage selects one pixel for the shared output amplifier. The output enable is raised only while a pixel of this section is on the output. The analog path is not modelled. The pixel being read is given as an index with a valid flag.

A hold input marks the end of integration. Its rising edge freezes every sample capacitor and starts an integrator-reset window of fixed length. When the pulse leaves the last stage it appears on the serial output. That output can drive the serial input of a second instance, so two sections read out one after the other to form a double-length line.

Top module: `lss_section`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs read zero after that edge: `pix_sel_o`, `out_en_o`, `pix_idx_o`, `pix_vld_o`, `int_rst_o`, `samp_hold_o`, `so_o` and `ovl_err_o`.
- R2: A 1 on `si_i` at a rising edge while the section is idle starts a readout. After that edge (edge 1), only bit 0 of `pix_sel_o` is set, `pix_idx_o` is 0, and both `out_en_o` and `pix_vld_o` are 1.
- R3: After edge k of a readout, for k from 1 to NPIX, exactly one bit of `pix_sel_o` is set. That bit is bit k-1, and `pix_idx_o` equals k-1.
- R4: `so_o` is 1 only after edge NPIX (768 by default) of a readout. It lasts exactly one cycle.
- R5: After edge NPIX+1, `out_en_o` and `pix_vld_o` are 0, `pix_sel_o` is all zero and `pix_idx_o` is 0.
- R6: A rising edge of `hold_i` seen at a clock edge while the section is idle raises `int_rst_o` after that edge. It stays high for exactly RST_CYC cycles (18 by default).
- R7: The same hold edge sets `samp_hold_o`. It stays set until edge NPIX+1 of the readout, which clears it.
- R8: A 1 on `si_i` at an edge during a readout raises `ovl_err_o` for the next cycle only. It does not change `pix_sel_o`, `pix_idx_o` or the integrator-reset window. A hold edge at the same time is ignored too.
- R9: With `so_o` of section A tied to `si_i` and `hold_i` of section B, B selects its pixel 0 after edge NPIX+1 of A. B raises its own `so_o` after edge 2·NPIX and drops it and its output enable after edge 2·NPIX+1.
- R10: A serial-input pulse at edge NPIX+2, the first edge after the output phase has ended, starts a new readout as in R2, R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| si_i | input | 1 | Serial start pulse |
| hold_i | input | 1 | Hold request; its rising edge ends integration |
| pix_sel_o | output | NPIX | One-hot pixel select, bit i selects pixel i |
| out_en_o | output | 1 | Output amplifier enable for this section |
| pix_idx_o | output | 10 | Index of the selected pixel |
| pix_vld_o | output | 1 | `pix_idx_o` is meaningful |
| int_rst_o | output | 1 | Integrator reset window active |
| samp_hold_o | output | 1 | Sample capacitors isolated from integrators |
| so_o | output | 1 | Serial output pulse for a following section |
| ovl_err_o | output | 1 | A start pulse arrived during a readout and was dropped |

## Verification
The assertions assume that `si_i` and `hold_i` change only between clock edges. They also assume a start pulse reaches the section at least one edge after the previous output phase has ended. Overlapping pulses are allowed but flagged. The bench keeps to these assumptions: it drives each input one time unit after a rising edge and ties hold to the serial input, as a real section would be wired. It offers overlapping pulses only in the directed case that checks they are dropped.

// File: rtl/lss_pkg.sv
// Shared defaults and types for the line sensor section sequencer.
// Assumes one section of NPIX pixels and a fixed integrator reset length.
package lss_pkg;
    localparam int NPIX_DEF    = 768;
    localparam int RST_CYC_DEF = 18;

    // Readout phase of a section.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_OUT  = 1'b1
    } phase_t;
endpackage

// File: rtl/lss_shift.sv
// Select shift register: a single 1 enters at stage 0 on a start and moves
// up one stage per clock. The last stage drives the serial output.
// Assumes start_i is high for at most one cycle per readout.
module lss_shift #(
    parameter int NPIX = 768
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic [NPIX-1:0] sel_o,
    output logic            so_o
);
    logic [NPIX-1:0] sr_q;

    generate
        if (NPIX == 1) begin : g_single
            // Purpose: hold the start bit for one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= start_i;
            end
        end else begin : g_chain
            // Purpose: advance the select token one pixel per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[NPIX-2:0], start_i};
            end
        end
    endgenerate

    assign sel_o = sr_q;
    assign so_o  = sr_q[NPIX-1];

    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sr_q));
    p_so_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (so_o && NPIX > 1) |=> !so_o);
endmodule

// File: rtl/lss_track.sv
// Readout tracker: keeps the phase and the pixel index, gives the start
// strobe and drops (and flags) a start pulse that arrives mid-readout.
// Assumes si_i is synchronous to clk.
module lss_track
    import lss_pkg::*;
#(
    parameter int NPIX  = 768,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             si_i,
    output logic             start_o,
    output logic             idle_o,
    output logic             last_o,
    output logic             out_en_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             ovl_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NPIX - 1);

    phase_t           ph_q;
    logic [IDX_W-1:0] idx_q;
    logic             ovl_q;

    assign idle_o  = (ph_q == PH_IDLE);
    assign start_o = si_i && idle_o;
    assign last_o  = (ph_q == PH_OUT) && (idx_q == IDX_LAST);

    // Purpose: step phase and pixel index through one readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            idx_q <= '0;
        end else if (start_o) begin
            ph_q  <= PH_OUT;
            idx_q <= '0;
        end else if (last_o) begin
            ph_q  <= PH_IDLE;
            idx_q <= '0;
        end else if (ph_q == PH_OUT) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Purpose: flag a start pulse that lands inside a readout.
    always_ff @(posedge clk) begin
        if (!rst_n) ovl_q <= 1'b0;
        else        ovl_q <= si_i && !idle_o;
    end

    assign out_en_o = (ph_q == PH_OUT);
    assign idx_o    = idx_q;
    assign ovl_o    = ovl_q;

    p_idx_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (idx_q == '0));
endmodule

// File: rtl/lss_rst_timer.sv
// Integrator reset timer and sample-hold flag. A rising edge on hold while
// idle loads the window counter and isolates the sample capacitors; the
// flag clears when the output phase ends.
// Assumes hold_i is synchronous to clk.
module lss_rst_timer #(
    parameter int RST_CYC = 18,
    parameter int CNT_W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic idle_i,
    input  logic end_i,
    output logic int_rst_o,
    output logic samp_hold_o
);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYC);

    logic             hold_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sh_q;
    logic             rise;

    assign rise = hold_i && !hold_q && idle_i;

    // Purpose: remember last hold level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_i;
    end

    // Purpose: count down the integrator reset window.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (rise)         cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Purpose: keep capacitors isolated from hold edge to end of output.
    always_ff @(posedge clk) begin
        if (!rst_n)      sh_q <= 1'b0;
        else if (rise)   sh_q <= 1'b1;
        else if (end_i)  sh_q <= 1'b0;
    end

    assign int_rst_o   = (cnt_q != '0);
    assign samp_hold_o = sh_q;

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);
    p_rst_with_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_rst_o) |-> samp_hold_o);
endmodule

// File: rtl/lss_section.sv
// One sensor section: ties the select shift register, the readout tracker
// and the integrator reset timer together. Chain sections by wiring so_o
// to the next section's si_i and hold_i.
// Assumes si_i and hold_i change away from the rising clock edge.
module lss_section
    import lss_pkg::*;
#(
    parameter int NPIX    = NPIX_DEF,
    parameter int RST_CYC = RST_CYC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            si_i,
    input  logic            hold_i,
    output logic [NPIX-1:0] pix_sel_o,
    output logic            out_en_o,
    output logic [9:0]      pix_idx_o,
    output logic            pix_vld_o,
    output logic            int_rst_o,
    output logic            samp_hold_o,
    output logic            so_o,
    output logic            ovl_err_o
);
    localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam int CNT_W = $clog2(RST_CYC + 1);

    logic             start;
    logic             idle;
    logic             last;
    logic [IDX_W-1:0] idx;

    lss_shift #(.NPIX(NPIX)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .sel_o   (pix_sel_o),
        .so_o    (so_o)
    );

    lss_track #(.NPIX(NPIX), .IDX_W(IDX_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .si_i     (si_i),
        .start_o  (start),
        .idle_o   (idle),
        .last_o   (last),
        .out_en_o (out_en_o),
        .idx_o    (idx),
        .ovl_o    (ovl_err_o)
    );

    lss_rst_timer #(.RST_CYC(RST_CYC), .CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold_i),
        .idle_i      (idle),
        .end_i       (last),
        .int_rst_o   (int_rst_o),
        .samp_hold_o (samp_hold_o)
    );

    assign pix_idx_o = 10'(idx);
    assign pix_vld_o = out_en_o;

    p_oe_matches_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_o == (pix_sel_o != '0));
    p_start_pixel0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en_o) |-> (pix_sel_o[0] && pix_idx_o == 10'd0));
    p_so_at_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        so_o |-> (pix_idx_o == 10'(NPIX - 1) && out_en_o));
    p_ovl_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (si_i && out_en_o && !last) |=> (out_en_o && pix_idx_o != 10'd0));
endmodule

// File: tb/lss_section_tb.sv
module lss_section_tb_top;
    localparam int NPIX = 768;
    localparam int RCYC = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic si = 1'b0;
    logic hold = 1'b0;

    logic [NPIX-1:0] a_sel, b_sel;
    logic [9:0]      a_idx, b_idx;
    logic a_oe, a_vld, a_ir, a_sh, a_so, a_ovl;
    logic b_oe, b_vld, b_ir, b_sh, b_so, b_ovl;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    lss_section #(.NPIX(NPIX), .RST_CYC(RCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .si_i(si), .hold_i(hold),
        .pix_sel_o(a_sel), .out_en_o(a_oe), .pix_idx_o(a_idx),
        .pix_vld_o(a_vld), .int_rst_o(a_ir), .samp_hold_o(a_sh),
        .so_o(a_so), .ovl_err_o(a_ovl)
    );

    lss_section #(.NPIX(NPIX), .RST_CYC(RCYC)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .si_i(a_so), .hold_i(a_so),
        .pix_sel_o(b_sel), .out_en_o(b_oe), .pix_idx_o(b_idx),
        .pix_vld_o(b_vld), .int_rst_o(b_ir), .samp_hold_o(b_sh),
        .so_o(b_so), .ovl_err_o(b_ovl)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        si = 1'b1; hold = 1'b1;
        tick();
        si = 1'b0; hold = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; si = 1'b0; hold = 1'b0;
        repeat (3) tick();
        chk(a_sel == '0, "R1 sel", $countones(a_sel), 0);
        chk({a_oe, a_vld, a_ir, a_sh, a_so, a_ovl} == 6'b0, "R1 flags",
            {a_oe, a_vld, a_ir, a_sh, a_so, a_ovl}, 0);
        chk(a_idx == 10'd0, "R1 idx", a_idx, 0);
        rst_n = 1'b1;
        tick();
        chk(a_oe == 1'b0 && b_oe == 1'b0, "R1 idle after release", a_oe, 0);
    endtask

    task automatic t_readout();
        pulse_start();
        chk(a_sel[0] && $countones(a_sel) == 1, "R2 sel", $countones(a_sel), 1);
        chk(a_idx == 10'd0 && a_vld && a_oe, "R2 idx/vld/oe", a_idx, 0);
        chk(a_ir == 1'b1, "R6 int_rst rise", a_ir, 1);
        chk(a_sh == 1'b1, "R7 samp_hold set", a_sh, 1);
        for (int k = 2; k <= NPIX; k++) begin
            tick();
            chk(a_sel[k-1] && $countones(a_sel) == 1, "R3 sel", $countones(a_sel), 1);
            chk(a_idx == 10'(k-1), "R3 idx", a_idx, k-1);
            chk(a_so == (k == NPIX), "R4 so", a_so, int'(k == NPIX));
            chk(a_ir == (k <= RCYC), "R6 int_rst window", a_ir, int'(k <= RCYC));
            chk(b_oe == 1'b0, "R9 B idle", b_oe, 0);
        end
        tick();
        chk(!a_oe && !a_vld && a_sel == '0 && a_idx == 10'd0, "R5 end", a_oe, 0);
        chk(a_so == 1'b0, "R4 so end", a_so, 0);
        chk(a_sh == 1'b0, "R7 samp_hold clear", a_sh, 0);
        chk(b_oe && b_sel[0] && b_idx == 10'd0, "R9 B start", b_idx, 0);
        for (int k = NPIX + 2; k <= 2 * NPIX; k++) begin
            tick();
            chk(b_idx == 10'(k - NPIX - 1), "R9 B idx", b_idx, k - NPIX - 1);
            chk(b_so == (k == 2 * NPIX), "R9 B so", b_so, int'(k == 2 * NPIX));
        end
        tick();
        chk(!b_so && !b_oe, "R9 B end", b_oe, 0);
    endtask

    task automatic t_overlap();
        pulse_start();
        repeat (4) tick();
        si = 1'b1; hold = 1'b1;
        tick();
        si = 1'b0; hold = 1'b0;
        chk(a_ovl == 1'b1, "R8 ovl flag", a_ovl, 1);
        chk(a_idx == 10'd5 && a_sel[5], "R8 idx kept", a_idx, 5);
        tick();
        chk(a_ovl == 1'b0, "R8 ovl one cycle", a_ovl, 0);
        repeat (RCYC - 7) tick();
        chk(a_ir == 1'b1, "R8 window last cycle", a_ir, 1);
        tick();
        chk(a_ir == 1'b0, "R8 no reload", a_ir, 0);
        repeat (NPIX + 1 - (RCYC + 1)) tick();
        chk(a_oe == 1'b0, "R8 readout length", a_oe, 0);
        repeat (NPIX + 1) tick();
    endtask

    task automatic t_back_to_back();
        pulse_start();
        repeat (NPIX) tick();
        chk(a_oe == 1'b0, "R10 first done", a_oe, 0);
        pulse_start();
        chk(a_oe && a_sel[0] && a_idx == 10'd0, "R10 restart", a_idx, 0);
        chk(a_ir && a_sh && !a_ovl, "R10 hold restart", a_ir, 1);
        repeat (NPIX) tick();
        chk(a_oe == 1'b0, "R10 second done", a_oe, 0);
        repeat (NPIX + 2) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_readout();
        t_overlap();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule